// File: doc/BRIEF.md
# PCM Frame-Synchronized Serial Port

This block is the serial side of a telephony voice codec channel. Once per 8 kHz frame it sends one parallel sample out as a serial word and collects one serial word into a parallel sample. An external bit clock (256 kHz to 4096 kHz, one data bit per period) sets the timing. Separate transmit and receive frame-sync inputs mark where each word starts. All logic runs on a faster system clock. The bit clock, both syncs and the serial input each pass through a synchronizer. Edges are found by comparing each synchronized signal with its value one system clock earlier.

The `short_mode` input selects the sync convention. In long-frame mode (0) a word starts at the rising edge of its sync. In short-frame mode (1) it starts at the falling edge. The transmit output is open-drain: the block only pulls the line low for a 0 bit and otherwise releases it. An active-low valid strobe is low exactly while sample bits are on the line, so it can enable an external line driver. Power-down releases the line and holds the strobe high.

The transmit state machine has three states. TX_OFF is the power-down state; it goes to TX_IDLE when power-down drops. TX_IDLE goes to TX_SHIFT on a start event and loads the sample. TX_SHIFT advances one bit per bit-clock rising edge. After the last bit it returns to TX_IDLE. A new start event in TX_SHIFT reloads and restarts the word, and power-down sends any state to TX_OFF.

The receive state machine also has three states. RX_IDLE goes to RX_SHIFT on a start event. RX_SHIFT samples one bit per bit-clock falling edge. A new start event restarts the word. After the last bit it goes to RX_DONE, which shows the new word for one system clock. RX_DONE then returns to RX_IDLE, or to RX_SHIFT if a start event arrives.

Top module: `pcm_frame_port`

## Requirements
- R1: After reset, `out_valid_n` is 1, `ser_pull_low` is 0, `rx_strobe` is 0 and `rx_sample` is all zeros.
- R2: With `short_mode`=0, a word starts at a rising edge of its frame sync. A falling edge of the sync in the middle of a word does not disturb the word.
- R3: With `short_mode`=1, a word starts at a falling edge of its frame sync. A rising edge of the sync does not start a word.
- R4: The transmit word goes out most significant bit first. The first bit appears at the start event and each later bit at a rising bit-clock edge. `tx_sample` is captured at the start event, and changing it later in the frame does not affect the word being sent.
- R5: `ser_pull_low` is 1 only while a 0 bit is being sent. A 1 bit, idle and power-down leave the line released.
- R6: `out_valid_n` is 0 for exactly the 8 bit periods of a word and 1 otherwise. After the last bit the line stays released through later bit-clock edges until the next start event.
- R7: While `power_down` is 1, the line is released and `out_valid_n` is 1 from the next system clock on, and start events are ignored. After `power_down` returns to 0, the next start event sends a normal word.
- R8: The receiver samples `ser_din` at 8 falling bit-clock edges after a start event, MSB first. It then updates `rx_sample` and raises `rx_strobe` for exactly one system clock. `rx_sample` changes at no other time.
- R9: A start event in the middle of a word restarts that direction. The partial receive word is dropped with no strobe, and the transmitter sends the newly captured sample from its MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Active-low reset |
| short_mode | input | 1 | Sync convention: 0 long-frame, 1 short-frame |
| power_down | input | 1 | Releases the transmit line and ignores transmit starts |
| bit_clk | input | 1 | Serial bit clock, asynchronous |
| tx_fsync | input | 1 | Transmit frame sync, asynchronous |
| rx_fsync | input | 1 | Receive frame sync, asynchronous |
| ser_din | input | 1 | Serial receive data |
| tx_sample | input | WORD_W | Parallel sample to send |
| ser_pull_low | output | 1 | Open-drain drive: 1 pulls the line low |
| out_valid_n | output | 1 | Active-low, low while sample bits are on the line |
| rx_sample | output | WORD_W | Last complete received sample |
| rx_strobe | output | 1 | One-clock pulse when `rx_sample` is updated |

## Verification
The hardest case to reach is a sync edge of the unselected polarity, or a second start edge, arriving while a word is partly shifted. A correct frame never shows it. To reach it, the bench drops the long-frame sync after the third bit of every word, and raises the short-frame sync one bit period before every word. It also aborts words after four bits and starts the next word at once. The same frame routine sweeps all 256 transmit and receive values in both modes. The expected serial word, strobe count and valid window are computed from the sample values.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        TX_OFF,
        TX_IDLE,
        TX_SHIFT
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SHIFT,
        RX_DONE
    } rx_state_t;

    // positions of the asynchronous inputs in the synchronizer vector
    localparam int unsigned IDX_BCLK  = 0;
    localparam int unsigned IDX_TXS   = 1;
    localparam int unsigned IDX_RXS   = 2;
    localparam int unsigned IDX_DIN   = 3;
    localparam int unsigned NUM_ASYNC = 4;
    localparam int unsigned NUM_EDGE  = 3;

    // start-of-word event for the selected sync convention
    function automatic logic word_start(input logic short_m,
                                        input logic sync_rise,
                                        input logic sync_fall);
        return short_m ? sync_fall : sync_rise;
    endfunction

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(STAGES); s++) begin
                chain[s] <= '0;
            end
        end else begin
            chain[0] <= raw;
            for (int s = 1; s < int'(STAGES); s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign level = chain[STAGES-1];
endmodule

// File: rtl/pcm_edge_det.sv
module pcm_edge_det #(
    parameter int unsigned N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= '0;
        end else begin
            prev <= level;
        end
    end

    for (genvar g = 0; g < int'(N); g++) begin : g_edge
        assign rise[g] = level[g] & ~prev[g];
        assign fall[g] = ~level[g] & prev[g];
    end
endmodule

// File: rtl/pcm_tx_fsm.sv
module pcm_tx_fsm
    import pcm_port_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              short_mode,
    input  logic              power_down,
    input  logic              sync_rise,
    input  logic              sync_fall,
    input  logic              bit_rise,
    input  logic [WORD_W-1:0] sample,
    output logic              pull_low,
    output logic              valid_n
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    tx_state_t         state_q, state_d;
    logic [WORD_W-1:0] shreg_q, shreg_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              start;

    assign start = word_start(short_mode, sync_rise, sync_fall);

    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TX_OFF: begin
                state_d = TX_IDLE;
            end
            TX_IDLE: begin
                if (start) begin
                    state_d = TX_SHIFT;
                    shreg_d = sample;
                    cnt_d   = '0;
                end
            end
            TX_SHIFT: begin
                if (start) begin
                    shreg_d = sample;
                    cnt_d   = '0;
                end else if (bit_rise) begin
                    if (cnt_q == LAST_BIT) begin
                        state_d = TX_IDLE;
                    end else begin
                        cnt_d   = cnt_q + 1'b1;
                        shreg_d = {shreg_q[WORD_W-2:0], 1'b0};
                    end
                end
            end
            default: begin
                state_d = TX_OFF;
            end
        endcase
        if (power_down) begin
            state_d = TX_OFF;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pull_low = 1'b0;
        valid_n  = 1'b1;
        unique case (state_q)
            TX_SHIFT: begin
                pull_low = ~shreg_q[WORD_W-1];
                valid_n  = 1'b0;
            end
            default: begin
                pull_low = 1'b0;
                valid_n  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pcm_rx_fsm.sv
module pcm_rx_fsm
    import pcm_port_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              short_mode,
    input  logic              sync_rise,
    input  logic              sync_fall,
    input  logic              bit_fall,
    input  logic              din,
    output logic [WORD_W-1:0] word,
    output logic              strobe
);
    localparam int unsigned CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    rx_state_t         state_q, state_d;
    logic [WORD_W-1:0] shreg_q, shreg_d;
    logic [WORD_W-1:0] word_q, word_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              start;

    assign start = word_start(short_mode, sync_rise, sync_fall);

    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        word_d  = word_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RX_IDLE, RX_DONE: begin
                if (start) begin
                    state_d = RX_SHIFT;
                    cnt_d   = '0;
                end else begin
                    state_d = RX_IDLE;
                end
            end
            RX_SHIFT: begin
                if (start) begin
                    cnt_d = '0;
                end else if (bit_fall) begin
                    shreg_d = {shreg_q[WORD_W-2:0], din};
                    if (cnt_q == LAST_BIT) begin
                        state_d = RX_DONE;
                        word_d  = {shreg_q[WORD_W-2:0], din};
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = RX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            shreg_q <= '0;
            word_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            word_q  <= word_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        word = word_q;
        unique case (state_q)
            RX_DONE: strobe = 1'b1;
            default: strobe = 1'b0;
        endcase
    end
endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              short_mode,
    input  logic              power_down,
    input  logic              bit_clk,
    input  logic              tx_fsync,
    input  logic              rx_fsync,
    input  logic              ser_din,
    input  logic [WORD_W-1:0] tx_sample,
    output logic              ser_pull_low,
    output logic              out_valid_n,
    output logic [WORD_W-1:0] rx_sample,
    output logic              rx_strobe
);
    logic [NUM_ASYNC-1:0] raw_vec;
    logic [NUM_ASYNC-1:0] sync_vec;
    logic [NUM_EDGE-1:0]  rise_vec;
    logic [NUM_EDGE-1:0]  fall_vec;

    logic bclk_rise, bclk_fall;
    logic txs_rise, txs_fall;
    logic rxs_rise, rxs_fall;

    always_comb begin
        raw_vec           = '0;
        raw_vec[IDX_BCLK] = bit_clk;
        raw_vec[IDX_TXS]  = tx_fsync;
        raw_vec[IDX_RXS]  = rx_fsync;
        raw_vec[IDX_DIN]  = ser_din;
    end

    pcm_in_sync #(
        .WIDTH  (NUM_ASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_vec),
        .level (sync_vec)
    );

    pcm_edge_det #(
        .N (NUM_EDGE)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_vec[NUM_EDGE-1:0]),
        .rise  (rise_vec),
        .fall  (fall_vec)
    );

    assign bclk_rise = rise_vec[IDX_BCLK];
    assign bclk_fall = fall_vec[IDX_BCLK];
    assign txs_rise  = rise_vec[IDX_TXS];
    assign txs_fall  = fall_vec[IDX_TXS];
    assign rxs_rise  = rise_vec[IDX_RXS];
    assign rxs_fall  = fall_vec[IDX_RXS];

    pcm_tx_fsm #(
        .WORD_W (WORD_W)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .short_mode (short_mode),
        .power_down (power_down),
        .sync_rise  (txs_rise),
        .sync_fall  (txs_fall),
        .bit_rise   (bclk_rise),
        .sample     (tx_sample),
        .pull_low   (ser_pull_low),
        .valid_n    (out_valid_n)
    );

    pcm_rx_fsm #(
        .WORD_W (WORD_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .short_mode (short_mode),
        .sync_rise  (rxs_rise),
        .sync_fall  (rxs_fall),
        .bit_fall   (bclk_fall),
        .din        (sync_vec[IDX_DIN]),
        .word       (rx_sample),
        .strobe     (rx_strobe)
    );
endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk #(
    parameter int unsigned WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              short_mode,
    input logic              power_down,
    input logic              bclk_rise,
    input logic              txs_rise,
    input logic              txs_fall,
    input logic              ser_pull_low,
    input logic              out_valid_n,
    input logic [WORD_W-1:0] rx_sample,
    input logic              rx_strobe
);
    // R5/R6: the line is never pulled low outside the valid window
    a_r5_pull_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        ser_pull_low |-> !out_valid_n);

    // R7: power-down releases the line on the next clock
    a_r7_power_down_release: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (out_valid_n && !ser_pull_low));

    // R2/R3/R6: the valid window opens only after a start event of the selected polarity
    a_r6_window_opens_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid_n) |-> $past(short_mode ? txs_fall : txs_rise));

    // R4: inside a word the driven bit moves only on a bit-clock rise or a restart
    a_r4_bit_moves_on_bclk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid_n && $past(!out_valid_n) && !$stable(ser_pull_low))
            |-> $past(bclk_rise || txs_rise || txs_fall));

    // R8: the receive strobe lasts one clock
    a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> !rx_strobe);

    // R8: the received word changes only together with the strobe
    a_r8_word_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe |-> $stable(rx_sample));
endmodule

bind pcm_frame_port pcm_frame_port_chk #(
    .WORD_W (WORD_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .short_mode   (short_mode),
    .power_down   (power_down),
    .bclk_rise    (bclk_rise),
    .txs_rise     (txs_rise),
    .txs_fall     (txs_fall),
    .ser_pull_low (ser_pull_low),
    .out_valid_n  (out_valid_n),
    .rx_sample    (rx_sample),
    .rx_strobe    (rx_strobe)
);

// File: tb/pcm_frame_port_bench.sv
`timescale 1ns/1ps
module pcm_frame_port_bench;
    localparam int HALF = 8;   // system clocks per bit-clock half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       short_mode = 1'b0;
    logic       power_down = 1'b0;
    logic       bit_clk = 1'b0;
    logic       tx_fsync = 1'b0;
    logic       rx_fsync = 1'b0;
    logic       ser_din = 1'b0;
    logic [7:0] tx_sample = '0;
    logic       ser_pull_low;
    logic       out_valid_n;
    logic [7:0] rx_sample;
    logic       rx_strobe;

    int n_cmp = 0;
    int n_bad = 0;
    int rx_pulses = 0;
    logic [7:0] rx_last = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pcm_frame_port u_pcm_frame_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .short_mode   (short_mode),
        .power_down   (power_down),
        .bit_clk      (bit_clk),
        .tx_fsync     (tx_fsync),
        .rx_fsync     (rx_fsync),
        .ser_din      (ser_din),
        .tx_sample    (tx_sample),
        .ser_pull_low (ser_pull_low),
        .out_valid_n  (out_valid_n),
        .rx_sample    (rx_sample),
        .rx_strobe    (rx_strobe)
    );

    always @(posedge clk) begin
        if (rx_strobe) begin
            rx_pulses <= rx_pulses + 1;
            rx_last   <= rx_sample;
        end
    end

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // one bit-clock period; sync and data change with the rising edge,
    // the outputs are sampled at the end of the high phase
    task automatic bclk_cycle(input logic sync_v, input logic din,
                              output logic pl, output logic vn);
        @(negedge clk);
        bit_clk  = 1'b1;
        tx_fsync = sync_v;
        rx_fsync = sync_v;
        ser_din  = din;
        repeat (HALF - 1) @(negedge clk);
        pl = ser_pull_low;
        vn = out_valid_n;
        @(negedge clk);
        bit_clk = 1'b0;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic run_frame(input logic sm, input logic [7:0] txw, input logic [7:0] rxw,
                             input int nbits, output logic [7:0] got, output int bad_vn);
        logic pl, vn;
        got    = '0;
        bad_vn = 0;
        tx_sample = txw;
        if (sm) bclk_cycle(1'b1, 1'b0, pl, vn);   // short sync: rise ignored
        for (int i = 0; i < nbits; i++) begin
            // long sync drops after bit 2, in mid word
            bclk_cycle(sm ? 1'b0 : (i < 3), rxw[7-i], pl, vn);
            got[7-i] = ~pl;
            if (vn !== 1'b0) bad_vn++;
            if (i == 0) tx_sample = ~txw;   // late change must be ignored (R4)
        end
    endtask

    task automatic idle_cycles(input int n, output int bad_pl, output int bad_vn);
        logic pl, vn;
        bad_pl = 0;
        bad_vn = 0;
        for (int i = 0; i < n; i++) begin
            bclk_cycle(1'b0, 1'b0, pl, vn);
            if (pl !== 1'b0) bad_pl++;
            if (vn !== 1'b1) bad_vn++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] got, got_b;
        logic [7:0] rxw;
        logic pl, vn;
        int bv, bv2, bp, bi;
        int p0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", {31'd0, out_valid_n}, 32'd1, "valid_n after reset");
        check("R1", {31'd0, ser_pull_low}, 32'd0, "pull_low after reset");
        check("R1", {31'd0, rx_strobe}, 32'd0, "strobe after reset");
        check("R1", {24'd0, rx_sample}, 32'd0, "rx word after reset");

        // sweep every value in both sync conventions
        for (int m = 0; m < 2; m++) begin
            short_mode = m[0];
            idle_cycles(1, bp, bi);
            for (int v = 0; v < 256; v++) begin
                rxw = 8'(v * 37 + 11);
                p0  = rx_pulses;
                run_frame(m[0], 8'(v), rxw, 8, got, bv);
                idle_cycles(2, bp, bi);
                check(m[0] ? "R3" : "R2", {24'd0, got}, v, "tx word framed, MSB first (R4)");
                check("R6", bv + bi, 0, "valid_n window");
                check("R5", bp, 0, "line released after last bit");
                check("R8", rx_pulses - p0, 1, "rx strobe count");
                check("R8", {24'd0, rx_last}, {24'd0, rxw}, "rx word");
            end
        end

        // restart in mid word, both conventions
        for (int m = 0; m < 2; m++) begin
            short_mode = m[0];
            idle_cycles(1, bp, bi);
            p0 = rx_pulses;
            run_frame(m[0], 8'hC3, 8'h96, 4, got, bv);
            run_frame(m[0], 8'h2D, 8'h71, 8, got_b, bv2);
            idle_cycles(2, bp, bi);
            check("R9", {28'd0, got[7:4]}, 32'hC, "partial word head");
            check("R9", {24'd0, got_b}, 32'h2D, "restarted tx word");
            check("R9", rx_pulses - p0, 1, "strobes across restart");
            check("R9", {24'd0, rx_last}, 32'h71, "rx word after restart");
        end

        // power-down in mid word, long convention
        short_mode = 1'b0;
        idle_cycles(1, bp, bi);
        tx_sample = 8'h00;
        bclk_cycle(1'b1, 1'b0, pl, vn);
        check("R5", {31'd0, pl}, 32'd1, "zero bit pulls low");
        check("R6", {31'd0, vn}, 32'd0, "valid during zero bit");
        @(negedge clk);
        power_down = 1'b1;
        @(negedge clk);
        check("R7", {30'd0, ser_pull_low, out_valid_n}, 32'd1, "released at power-down");
        idle_cycles(3, bp, bi);
        check("R7", bp + bi, 0, "stays released");
        run_frame(1'b0, 8'h00, 8'h00, 8, got, bv);
        check("R7", {24'd0, got}, 32'hFF, "start ignored in power-down");
        check("R7", bv, 8, "valid_n high in power-down");
        idle_cycles(1, bp, bi);
        power_down = 1'b0;
        idle_cycles(1, bp, bi);
        run_frame(1'b0, 8'h5C, 8'hA7, 8, got, bv);
        idle_cycles(2, bp, bi);
        check("R7", {24'd0, got}, 32'h5C, "word after power-up");
        check("R7", bv, 0, "valid after power-up");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule